// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two parallel buses, called A and B, in either direction. Each direction has its own storage register. That register loads on a rising edge of a strobe belonging to that direction. The edge is found by sampling the strobe on the system clock. A per-direction select chooses what the driven bus carries: live data taken straight from the opposite bus, or the contents of the register that belongs to the opposite bus.

Pins are modelled as separate input, output and output-enable vectors for each bus. A side that is not driven shows zero on its output vector and clears its enables. The register loads from the resolved bus, meaning the driven value when the block drives that side and the pin input otherwise. As a result, data that is passing through to a bus can be captured into that bus's own register.

A parameter picks the enable decoding. One choice uses an active-low global enable with a direction pin. The other uses two independent enables: an active-high A-to-B enable and an active-low B-to-A enable. A second parameter makes the transfer paths invert the data.

Top module: `bidir_xfer_reg`

## Requirements
- R1: While `rst_n` is low, all output enables and output data are zero. After reset both registers hold zero, so a stored transfer drives 0x00.
- R2: A rising edge of `clk_ab`, seen at a system clock edge, loads the resolved A bus into the A register. The A register becomes visible after that edge. This happens whatever the enables and selects are.
- R3: A rising edge of `clk_ba` loads the resolved B bus into the B register in the same way.
- R4: Select 0 sends the live input of the opposite bus to the driven side. Select 1 sends the register of the opposite bus instead. `sel_ab` feeds the B side and `sel_ba` feeds the A side.
- R5: In the enable/direction style (CTRL_ENDIR), `g_n`=1 drives neither side, but the strobes still load the registers.
- R6: In the enable/direction style with `g_n`=0, `dir`=1 drives B and `dir`=0 drives A. Both sides are never driven together.
- R7: In the two-enable style (CTRL_DUAL), `en_ab`=1 drives B and `en_ba_n`=0 drives A. The two enables are independent, so both sides can be driven at once.
- R8: If B is being driven when `clk_ba` rises, the B register takes the driven value rather than `b_in`. The mirror case applies to A. This lets one bus's data end up in both registers.
- R9: When both strobes rise together, each register loads its own bus.
- R10: With INVERT=1, each transfer path outputs the bitwise complement of the value it selects. The registers keep the bus value as it appeared on the bus.
- R11: Each output-enable vector is either all zeros or all ones. A side that is not driven outputs 0x00.
- R12: Holding a strobe high over several system clock edges loads the register only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | WIDTH | A bus pin input |
| b_in | input | WIDTH | B bus pin input |
| a_out | output | WIDTH | A bus driven data |
| a_oe | output | WIDTH | A bus output enables |
| b_out | output | WIDTH | B bus driven data |
| b_oe | output | WIDTH | B bus output enables |
| clk_ab | input | 1 | A register load strobe |
| clk_ba | input | 1 | B register load strobe |
| sel_ab | input | 1 | B side source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A side source: 0 live B, 1 stored B |
| g_n | input | 1 | Global enable, active low (enable/direction style) |
| dir | input | 1 | Direction, 1 = A to B (enable/direction style) |
| en_ab | input | 1 | B side drive enable, active high (two-enable style) |
| en_ba_n | input | 1 | A side drive enable, active low (two-enable style) |

## Verification
The bench builds two instances that share their inputs. The first uses the two-enable style without inversion, so both sides can be driven at once and data can be stored into both registers. The second uses the enable/direction style with inversion, which exercises isolation, single-side direction control and complemented data on both the live and the stored paths. Between them, both control decoders and both polarity variants are reached.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
   typedef enum logic {
      CTRL_ENDIR = 1'b0,
      CTRL_DUAL  = 1'b1
   } ctrl_style_e;
endpackage

// File: rtl/bxr_edge_store.sv
module bxr_edge_store #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic strobe_d;
   logic rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_d <= 1'b0;
      else        strobe_d <= strobe;
   end

   assign rise = strobe & ~strobe_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (rise) q <= d;
   end
endmodule

// File: rtl/bxr_drive_ctl.sv
module bxr_drive_ctl #(
   parameter bxr_pkg::ctrl_style_e CTRL = bxr_pkg::CTRL_DUAL
) (
   input  logic rst_n,
   input  logic g_n,
   input  logic dir,
   input  logic en_ab,
   input  logic en_ba_n,
   output logic drv_a,
   output logic drv_b
);
   generate
      if (CTRL == bxr_pkg::CTRL_ENDIR) begin : g_endir
         logic ctl_unused;
         assign ctl_unused = en_ab ^ en_ba_n;
         assign drv_a = rst_n & ~g_n & ~dir;
         assign drv_b = rst_n & ~g_n &  dir;
      end else begin : g_dual
         logic ctl_unused;
         assign ctl_unused = g_n ^ dir;
         assign drv_a = rst_n & ~en_ba_n;
         assign drv_b = rst_n &  en_ab;
      end
   endgenerate
endmodule

// File: rtl/bxr_path.sv
module bxr_path #(
   parameter int W      = 8,
   parameter bit INVERT = 1'b0
) (
   input  logic         sel,
   input  logic         drive,
   input  logic [W-1:0] live,
   input  logic [W-1:0] stored,
   output logic [W-1:0] out,
   output logic [W-1:0] oe
);
   logic [W-1:0] pick;
   logic [W-1:0] polar;

   assign pick = sel ? stored : live;

   generate
      if (INVERT) begin : g_inv
         assign polar = ~pick;
      end else begin : g_pass
         assign polar = pick;
      end
   endgenerate

   assign out = drive ? polar : '0;
   assign oe  = {W{drive}};
endmodule

// File: rtl/bidir_xfer_reg.sv
module bidir_xfer_reg #(
   parameter int                   WIDTH  = 8,
   parameter bxr_pkg::ctrl_style_e CTRL   = bxr_pkg::CTRL_DUAL,
   parameter bit                   INVERT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe,
   input  logic             clk_ab,
   input  logic             clk_ba,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic             g_n,
   input  logic             dir,
   input  logic             en_ab,
   input  logic             en_ba_n
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("bidir_xfer_reg: WIDTH must be at least 1");
      end
   endgenerate

   logic             drv_a;
   logic             drv_b;
   logic [WIDTH-1:0] a_bus;
   logic [WIDTH-1:0] b_bus;
   logic [WIDTH-1:0] reg_a_q;
   logic [WIDTH-1:0] reg_b_q;

   // Resolved bus values: what the register sees on the pins.
   assign a_bus = drv_a ? a_out : a_in;
   assign b_bus = drv_b ? b_out : b_in;

   bxr_drive_ctl #(.CTRL(CTRL)) u_ctl (
      .rst_n   (rst_n),
      .g_n     (g_n),
      .dir     (dir),
      .en_ab   (en_ab),
      .en_ba_n (en_ba_n),
      .drv_a   (drv_a),
      .drv_b   (drv_b)
   );

   bxr_edge_store #(.W(WIDTH)) u_store_a (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (clk_ab),
      .d      (a_bus),
      .q      (reg_a_q)
   );

   bxr_edge_store #(.W(WIDTH)) u_store_b (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (clk_ba),
      .d      (b_bus),
      .q      (reg_b_q)
   );

   bxr_path #(.W(WIDTH), .INVERT(INVERT)) u_path_ab (
      .sel    (sel_ab),
      .drive  (drv_b),
      .live   (a_in),
      .stored (reg_a_q),
      .out    (b_out),
      .oe     (b_oe)
   );

   bxr_path #(.W(WIDTH), .INVERT(INVERT)) u_path_ba (
      .sel    (sel_ba),
      .drive  (drv_a),
      .live   (b_in),
      .stored (reg_b_q),
      .out    (a_out),
      .oe     (a_oe)
   );
endmodule

// File: rtl/bidir_xfer_reg_chk.sv
module bidir_xfer_reg_chk #(
   parameter int                   W    = 8,
   parameter bxr_pkg::ctrl_style_e CTRL = bxr_pkg::CTRL_DUAL
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clk_ab,
   input logic         clk_ba,
   input logic [W-1:0] a_in,
   input logic [W-1:0] b_in,
   input logic [W-1:0] a_out,
   input logic [W-1:0] b_out,
   input logic [W-1:0] a_oe,
   input logic [W-1:0] b_oe,
   input logic [W-1:0] reg_a,
   input logic [W-1:0] reg_b
);
   // R1: quiet outputs while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0)
            else $error("R1 outputs active during reset");
      end
   end

   // R2: strobe rise loads the resolved A bus
   a_r2_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_ab) |=> reg_a == $past(a_oe[0] ? a_out : a_in));

   // R3: strobe rise loads the resolved B bus
   a_r3_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_ba) |=> reg_b == $past(b_oe[0] ? b_out : b_in));

   // R12: a held strobe does not load again
   a_r12_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_ab && $past(clk_ab) && $past(rst_n)) |=> $stable(reg_a));

   a_r12_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_ba && $past(clk_ba) && $past(rst_n)) |=> $stable(reg_b));

   // R11: enables are uniform, idle side outputs zero
   a_r11_uniform_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1));

   a_r11_idle_a_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe == '0) |-> (a_out == '0));

   a_r11_idle_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe == '0) |-> (b_out == '0));

   generate
      if (CTRL == bxr_pkg::CTRL_ENDIR) begin : g_one_side
         // R6: never both sides in the enable/direction style
         a_r6_one_side: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_oe[0] && b_oe[0]));
      end
   endgenerate
endmodule

bind bidir_xfer_reg bidir_xfer_reg_chk #(.W(WIDTH), .CTRL(CTRL)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .clk_ab (clk_ab),
   .clk_ba (clk_ba),
   .a_in   (a_in),
   .b_in   (b_in),
   .a_out  (a_out),
   .b_out  (b_out),
   .a_oe   (a_oe),
   .b_oe   (b_oe),
   .reg_a  (reg_a_q),
   .reg_b  (reg_b_q)
);

// File: tb/tb_bidir_xfer_reg.sv
`timescale 1ns/1ps
module tb_bidir_xfer_reg;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         clk_ab = 1'b0, clk_ba = 1'b0;
   logic         sel_ab = 1'b0, sel_ba = 1'b0;
   logic         g_n = 1'b1, dir = 1'b0;
   logic         en_ab = 1'b0, en_ba_n = 1'b1;

   logic [W-1:0] a_out, a_oe, b_out, b_oe;
   logic [W-1:0] d_a_out, d_a_oe, d_b_out, d_b_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bidir_xfer_reg #(.WIDTH(W), .CTRL(bxr_pkg::CTRL_DUAL), .INVERT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
      .clk_ab(clk_ab), .clk_ba(clk_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .g_n(g_n), .dir(dir), .en_ab(en_ab), .en_ba_n(en_ba_n));

   bidir_xfer_reg #(.WIDTH(W), .CTRL(bxr_pkg::CTRL_ENDIR), .INVERT(1'b1)) dut_dir (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .a_out(d_a_out), .a_oe(d_a_oe), .b_out(d_b_out), .b_oe(d_b_oe),
      .clk_ab(clk_ab), .clk_ba(clk_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .g_n(g_n), .dir(dir), .en_ab(en_ab), .en_ba_n(en_ba_n));

   typedef struct packed {
      logic       en_ab, en_ba_n, sel_ab, sel_ba, cab, cba;
      logic [7:0] a, b, ea;
      logic       eaoe;
      logic [7:0] eb;
      logic       eboe;
   } vec_t;

   // Vectors for dut (two-enable style, non-inverting)
   localparam vec_t TBL [12] = '{
      '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h11,8'h22, 8'h00,1'b0, 8'h00,1'b0}, // R11 idle
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h3C,8'h00, 8'h00,1'b0, 8'h3C,1'b1}, // R4 live A to B
      '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 8'h5A,8'h00, 8'h00,1'b0, 8'h5A,1'b1}, // R2 store A
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h77,8'h81, 8'h81,1'b1, 8'h00,1'b0}, // R7 A side only
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 8'h00,8'hC3, 8'hC3,1'b1, 8'h00,1'b0}, // R3 store B
      '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'hFF,8'hFF, 8'hC3,1'b1, 8'h5A,1'b1}, // R7 both driven
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'hE7,8'h00, 8'h00,1'b0, 8'hE7,1'b1}, // R8 A into B reg
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,8'h00, 8'hE7,1'b1, 8'h00,1'b0}, // R8 reveal
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00,8'h96, 8'h96,1'b1, 8'h00,1'b0}, // R8 B into A reg
      '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00, 8'h00,1'b0, 8'h96,1'b1}, // R8 reveal
      '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 8'h12,8'h34, 8'h00,1'b0, 8'h00,1'b0}, // R9 both strobes
      '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'h00,8'h00, 8'h34,1'b1, 8'h12,1'b1}  // R9 reveal
   };

   function automatic string tag_of(input int i);
      case (i)
         0: return "R11";
         1: return "R4";
         2: return "R2";
         3: return "R7";
         4: return "R3";
         5: return "R7";
         6, 7, 8, 9: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic strobes_low();
      @(negedge clk);
      clk_ab = 1'b0;
      clk_ba = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: drive requests during reset must stay quiet
      en_ab = 1'b1; en_ba_n = 1'b0; g_n = 1'b0; dir = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", a_oe, 8'h00);
      chk("R1", b_oe, 8'h00);
      chk("R1", d_b_oe, 8'h00);
      @(negedge clk);
      en_ab = 1'b0; en_ba_n = 1'b1; g_n = 1'b1; dir = 1'b0;
      rst_n = 1'b1;

      // R1: registers start at zero
      @(negedge clk);
      en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
      a_in = 8'hA5; b_in = 8'h5A;
      @(posedge clk); #1;
      chk("R1", b_out, 8'h00);
      chk("R1", a_out, 8'h00);
      chk("R1", b_oe, 8'hFF);
      @(negedge clk);
      en_ab = 1'b0; en_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;

      // Vector table on dut
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         en_ab = TBL[i].en_ab; en_ba_n = TBL[i].en_ba_n;
         sel_ab = TBL[i].sel_ab; sel_ba = TBL[i].sel_ba;
         clk_ab = TBL[i].cab; clk_ba = TBL[i].cba;
         a_in = TBL[i].a; b_in = TBL[i].b;
         @(posedge clk); #1;
         chk(tag_of(i), a_out, TBL[i].ea);
         chk(tag_of(i), a_oe, {8{TBL[i].eaoe}});
         chk(tag_of(i), b_out, TBL[i].eb);
         chk(tag_of(i), b_oe, {8{TBL[i].eboe}});
         strobes_low();
      end

      // R12: held strobe loads only once
      @(negedge clk);
      en_ab = 1'b1; en_ba_n = 1'b1; sel_ab = 1'b1; clk_ab = 1'b1; a_in = 8'hAA;
      @(posedge clk); #1;
      chk("R12", b_out, 8'hAA);
      @(negedge clk);
      a_in = 8'hBB;
      @(posedge clk);
      @(posedge clk); #1;
      chk("R12", b_out, 8'hAA);
      strobes_low();
      en_ab = 1'b0;

      // dut_dir: enable/direction style, inverting
      // R5: isolation while the strobe still loads
      @(negedge clk);
      g_n = 1'b1; dir = 1'b1; sel_ab = 1'b1; clk_ab = 1'b1; a_in = 8'h0F;
      @(posedge clk); #1;
      chk("R5", d_a_oe, 8'h00);
      chk("R5", d_b_oe, 8'h00);
      chk("R5", d_b_out, 8'h00);
      strobes_low();

      // R5/R6/R10: enabled towards B shows the complemented stored value
      @(negedge clk);
      g_n = 1'b0; a_in = 8'h00;
      @(posedge clk); #1;
      chk("R10", d_b_out, 8'hF0);
      chk("R6", d_b_oe, 8'hFF);
      chk("R6", d_a_oe, 8'h00);

      // R4/R10: live path is complemented too
      @(negedge clk);
      sel_ab = 1'b0; a_in = 8'h33;
      @(posedge clk); #1;
      chk("R4", d_b_out, 8'hCC);

      // R6: direction low drives A only
      @(negedge clk);
      dir = 1'b0; sel_ba = 1'b0; b_in = 8'h55;
      @(posedge clk); #1;
      chk("R6", d_a_out, 8'hAA);
      chk("R6", d_a_oe, 8'hFF);
      chk("R6", d_b_oe, 8'h00);

      // R10: register keeps the bus value uncomplemented
      @(negedge clk);
      clk_ba = 1'b1; b_in = 8'h01;
      @(posedge clk);
      strobes_low();
      sel_ba = 1'b1; b_in = 8'h00;
      @(posedge clk); #1;
      chk("R10", d_a_out, 8'hFE);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule